// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Burst and Cycle-Steal Modes

This block moves a block of bytes between one peripheral and memory without help from the processor. Software first loads a start address, then writes a control word that holds a byte count, a mode bit and a direction bit. The control write starts the transfer. The engine asks the processor for the bus, waits until the bus is granted, moves the bytes one memory cycle at a time and then hands the bus back. A one-cycle completion pulse marks the end of the block.

Two modes are available. In burst mode the engine keeps the bus from the first byte to the last. In cycle-steal mode it gives the bus up after every byte. It then waits until the peripheral reports the next byte ready and repeats the request/grant handshake for that byte. Each transfer happens in the cycle in which the engine owns a granted bus and the peripheral is ready. The memory strobe and the peripheral acknowledge appear together in that cycle.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: During reset and after it is released, busReq, memRd, memWr, perAck and doneIrq are low and memAddr is zero.
- R2: memRd or memWr is asserted only while busReq and busGrant are both high. memAddr reads zero whenever busGrant is low.
- R3: Each transfer is one cycle with perAck high and exactly one memory strobe. With direction bit 0, memWr is used and memWrData equals perWrData. With direction bit 1, memRd is used and perRdData equals memRdData. The address starts at the loaded value and rises by one per transfer, across blocks when it is not reloaded. Exactly count transfers occur.
- R4: In burst mode (mode bit 0), busReq stays high from its first assertion until the cycle after the final transfer.
- R5: In cycle-steal mode (mode bit 1), busReq is low in the cycle after every transfer. It is raised again only after perReady is seen high.
- R6: In the cycle after the final transfer, busReq is low and doneIrq is high. doneIrq is low again one cycle later.
- R7: A control write with count zero raises doneIrq in the next cycle and never raises busReq.
- R8: Register writes of either kind are ignored while a block is in progress. The address sequence and the transfer count of the running block are unchanged, and no new block starts afterwards.
- R9: Register encoding. With regSel 0, regWrData[ADDR_W-1:0] is the start address. With regSel 1, bits [CNT_W-1:0] hold the count, bit CNT_W the mode and bit CNT_W+1 the direction, and the write starts a block. In burst mode busReq rises in the cycle after the write. In cycle-steal mode it stays low in that cycle.
- R10: While the bus is held and perReady is low, no strobe or acknowledge is issued and burst mode keeps busReq high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the start address, 1 selects the control word |
| regWrData | input | REG_W | Register write data |
| busReq | output | 1 | Request for the system bus |
| busGrant | input | 1 | Bus granted by the processor |
| memAddr | output | ADDR_W | Memory address, zero while the bus is not owned |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memWrData | output | DATA_W | Data written to memory |
| memRdData | input | DATA_W | Data read from memory in the strobe cycle |
| perReady | input | 1 | Peripheral has data ready or can accept data |
| perAck | output | 1 | Transfer acknowledge to the peripheral |
| perWrData | input | DATA_W | Byte supplied by the peripheral |
| perRdData | output | DATA_W | Byte delivered to the peripheral, valid with perAck |
| doneIrq | output | 1 | One-cycle block completion pulse |

## Verification
The control write is taken on a rising edge. In burst mode busReq is due in the very next cycle. In cycle-steal mode the request is first held back one cycle for the readiness check. Strobes, address and acknowledge are combinational in the cycle of ownership plus readiness. busReq drops and doneIrq rises one cycle after the final strobe, and a zero-count write gives doneIrq one cycle after the write. The bench drives inputs on the falling edge and samples two nanoseconds later, after the inputs have settled, so every sample sees the state left by the preceding rising edge. Because the bench's processor model grants one cycle after each request, the per-cycle monitors can keep a running expected address and a record of the previous acknowledge, and compare each cycle against them.

// File: rtl/dma_xfer_pkg.sv
`timescale 1ns/1ps
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_PER = 2'd1,
    ST_REQ      = 2'd2,
    ST_OWN      = 2'd3
  } dmaState_t;

  // control -> datapath
  typedef struct packed {
    logic ldAddr;
    logic ldCtrl;
    logic step;
  } dmaStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lastByte;
    logic stealMode;
    logic toPeriph;
  } dmaStatus_t;

endpackage

// File: rtl/dma_xfer_datapath.sv
`timescale 1ns/1ps
module dma_xfer_datapath
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic              ownBus,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] perWrData,
  output dmaStatus_t        status,
  output logic              wrCountZero,
  output logic              wrSteal,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] perRdData
);

  localparam int MODE_BIT = CNT_W;
  localparam int DIR_BIT  = CNT_W + 1;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;
  logic              stealQ;
  logic              toPerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.ldAddr) begin
      addrQ <= regWrData[ADDR_W-1:0];
    end else if (strobe.step) begin
      addrQ <= addrQ + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      stealQ <= 1'b0;
      toPerQ <= 1'b0;
    end else if (strobe.ldCtrl) begin
      cntQ   <= regWrData[CNT_W-1:0];
      stealQ <= regWrData[MODE_BIT];
      toPerQ <= regWrData[DIR_BIT];
    end else if (strobe.step) begin
      cntQ   <= cntQ - CNT_W'(1);
    end
  end

  always_comb begin
    wrCountZero      = (regWrData[CNT_W-1:0] == '0);
    wrSteal          = regWrData[MODE_BIT];
    status.lastByte  = (cntQ == CNT_W'(1));
    status.stealMode = stealQ;
    status.toPeriph  = toPerQ;
    memAddr          = ownBus ? addrQ : '0;
    memWrData        = (ownBus && !toPerQ) ? perWrData : '0;
    perRdData        = (strobe.step && toPerQ) ? memRdData : '0;
  end

endmodule

// File: rtl/dma_xfer_ctrl_fsm.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_fsm
  import dma_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic       wrCountZero,
  input  logic       wrSteal,
  input  dmaStatus_t status,
  input  logic       busGrant,
  input  logic       perReady,
  output dmaStrobe_t strobe,
  output logic       ownBus,
  output logic       busReq,
  output logic       memRd,
  output logic       memWr,
  output logic       perAck,
  output logic       doneIrq
);

  dmaState_t stateQ, stateD;
  logic      idle;
  logic      ctrlWr;
  logic      ctrlGo;
  logic      zeroDone;
  logic      fire;
  logic      doneQ;

  always_comb begin
    idle     = (stateQ == ST_IDLE);
    ctrlWr   = regWrEn && regSel && idle;
    ctrlGo   = ctrlWr && !wrCountZero;
    zeroDone = ctrlWr && wrCountZero;
    ownBus   = (stateQ == ST_OWN) && busGrant;
    fire     = ownBus && perReady;

    strobe.ldAddr = regWrEn && !regSel && idle;
    strobe.ldCtrl = ctrlGo;
    strobe.step   = fire;

    busReq  = (stateQ == ST_REQ) || (stateQ == ST_OWN);
    memRd   = fire && status.toPeriph;
    memWr   = fire && !status.toPeriph;
    perAck  = fire;
    doneIrq = doneQ;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (ctrlGo) stateD = wrSteal ? ST_WAIT_PER : ST_REQ;
      end
      ST_WAIT_PER: begin
        if (perReady) stateD = ST_REQ;
      end
      ST_REQ: begin
        if (busGrant) stateD = ST_OWN;
      end
      ST_OWN: begin
        if (fire) begin
          if (status.lastByte)       stateD = ST_IDLE;
          else if (status.stealMode) stateD = ST_WAIT_PER;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= zeroDone || (fire && status.lastByte);
    end
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
`timescale 1ns/1ps
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int REG_W  = (ADDR_W > CNT_W + 2) ? ADDR_W : CNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              perReady,
  output logic              perAck,
  input  logic [DATA_W-1:0] perWrData,
  output logic [DATA_W-1:0] perRdData,
  output logic              doneIrq
);

  dmaStrobe_t strobeW;
  dmaStatus_t statusW;
  logic       ownBusW;
  logic       wrCountZeroW;
  logic       wrStealW;

  dma_xfer_ctrl_fsm u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .wrCountZero (wrCountZeroW),
    .wrSteal     (wrStealW),
    .status      (statusW),
    .busGrant    (busGrant),
    .perReady    (perReady),
    .strobe      (strobeW),
    .ownBus      (ownBusW),
    .busReq      (busReq),
    .memRd       (memRd),
    .memWr       (memWr),
    .perAck      (perAck),
    .doneIrq     (doneIrq)
  );

  dma_xfer_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobeW),
    .ownBus      (ownBusW),
    .regWrData   (regWrData),
    .memRdData   (memRdData),
    .perWrData   (perWrData),
    .status      (statusW),
    .wrCountZero (wrCountZeroW),
    .wrSteal     (wrStealW),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .perRdData   (perRdData)
  );

endmodule

// File: rtl/dma_xfer_sva.sv
`timescale 1ns/1ps
module dma_xfer_sva #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGrant,
  input logic              memRd,
  input logic              memWr,
  input logic              perAck,
  input logic              perReady,
  input logic              doneIrq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              stealMode,
  input logic              lastByte
);

  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (busReq && busGrant)); // R2

  AST_ADDR_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    !busGrant |-> (memAddr == '0)); // R2

  AST_ONE_STROBE_PER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> ($countones({memRd, memWr}) == 1)); // R3

  AST_STROBE_HAS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> perAck); // R3

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (perAck && !stealMode && !lastByte) |=> busReq); // R4

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (perAck && stealMode) |=> !busReq); // R5

  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (perAck && lastByte) |=> (!busReq && doneIrq)); // R6

  AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busReq); // R7

  AST_ACK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> perReady); // R10

endmodule

bind dma_xfer_ctrl dma_xfer_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busGrant  (busGrant),
  .memRd     (memRd),
  .memWr     (memWr),
  .perAck    (perAck),
  .perReady  (perReady),
  .doneIrq   (doneIrq),
  .memAddr   (memAddr),
  .stealMode (statusW.stealMode),
  .lastByte  (statusW.lastByte)
);

// File: tb/test_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module test_dma_xfer_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic        busReq;
  logic        busGrant = 1'b0;
  logic [15:0] memAddr;
  logic        memRd;
  logic        memWr;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData;
  logic        perReady = 1'b0;
  logic        perAck;
  logic [7:0]  perData = '0;
  logic [7:0]  perRdData;
  logic        doneIrq;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  dma_xfer_ctrl i_dma_xfer_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .busReq    (busReq),
    .busGrant  (busGrant),
    .memAddr   (memAddr),
    .memRd     (memRd),
    .memWr     (memWr),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .perReady  (perReady),
    .perAck    (perAck),
    .perWrData (perData),
    .perRdData (perRdData),
    .doneIrq   (doneIrq)
  );

  // memory and processor models
  assign memRdData = mem[memAddr[7:0]];
  always @(posedge clk) if (memWr) mem[memAddr[7:0]] <= memWrData;
  always @(posedge clk) busGrant <= rstN ? busReq : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busReq && !memRd && !memWr && !perAck && !doneIrq && memAddr == 0, "R1 in reset",
        {busReq, memRd, memWr, perAck, doneIrq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(!busReq && !memRd && !memWr && !perAck && !doneIrq && memAddr == 0, "R1 after reset",
        {busReq, memRd, memWr, perAck, doneIrq}, 0);
  endtask

  task automatic loadAddr(input logic [15:0] a);
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = a;
  endtask

  // Writes the control word and runs the block, checking every cycle.
  task automatic runBlock(input string tag, input bit steal, input bit toPer,
                          input logic [15:0] start, input int n, input bit slowPer,
                          input bit poke);
    int   xfers = 0;
    int   cyc = 0;
    bit   sawDone = 0, prevAck = 0, started = 0;
    bit   grantBad = 0, addrBad = 0, dataBad = 0, stealBad = 0, burstBad = 0;
    bit   doneBad = 0, stallBad = 0, firstBad = 0;
    logic [15:0] expAddr = start;
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b1;
    regWrData = {2'b00, toPer, steal, 12'(n)};
    while (!sawDone && cyc < 300) begin
      @(negedge clk);
      regWrEn = 1'b0;
      cyc++;
      perReady = slowPer ? (cyc % 3 == 0) : 1'b1;
      perData = 8'hC3 + 8'(xfers);
      if (poke && cyc == 4) begin regWrEn = 1'b1; regSel = 1'b0; regWrData = 16'h0080; end
      if (poke && cyc == 5) begin regWrEn = 1'b1; regSel = 1'b1; regWrData = 16'h0001; end
      #2;
      if (cyc == 1 && busReq != !steal) firstBad = 1;               // R9
      if ((memRd || memWr) && !busGrant) grantBad = 1;              // R2
      if (!busGrant && memAddr != 0) grantBad = 1;                  // R2
      if (!perReady && (perAck || memRd || memWr)) stallBad = 1;    // R10
      if (steal && prevAck && busReq) stealBad = 1;                 // R5
      if (doneIrq) begin
        sawDone = 1;
        if (busReq || !prevAck || xfers != n) doneBad = 1;          // R6
      end else if (!steal && started && !busReq) burstBad = 1;      // R4
      if (busReq) started = 1;
      if (perAck) begin
        if (memAddr != expAddr) addrBad = 1;                        // R3
        if (toPer) begin
          if (!memRd || memWr || perRdData != mem[expAddr[7:0]]) dataBad = 1;
        end else begin
          if (!memWr || memRd || memWrData != perData) dataBad = 1;
        end
        expAddr++;
        xfers++;
      end
      prevAck = perAck;
    end
    chk(sawDone, {tag, " R6 done seen"}, sawDone, 1);
    chk(xfers == n, {tag, " R3 transfer count"}, xfers, n);
    chk(!addrBad, {tag, " R3 address sequence"}, addrBad, 0);
    chk(!dataBad, {tag, " R3 strobe and data"}, dataBad, 0);
    chk(!grantBad, {tag, " R2 bus use without grant"}, grantBad, 0);
    chk(!firstBad, {tag, " R9 first request cycle"}, firstBad, 0);
    chk(!doneBad, {tag, " R6 release with done"}, doneBad, 0);
    if (steal) chk(!stealBad, {tag, " R5 release after each byte"}, stealBad, 0);
    else       chk(!burstBad, {tag, " R4 bus held"}, burstBad, 0);
    if (slowPer) chk(!stallBad, {tag, " R10 stall"}, stallBad, 0);
    @(negedge clk);
    #2;
    chk(!doneIrq && !busReq, {tag, " R6 done one cycle"}, {doneIrq, busReq}, 0);
    if (!toPer) begin
      bit memBad = 0;
      for (int i = 0; i < n; i++)
        if (mem[8'(start + 16'(i))] != 8'hC3 + 8'(i)) memBad = 1;
      chk(!memBad, {tag, " R3 memory contents"}, memBad, 0);
    end
  endtask

  task automatic t_burst_to_mem();
    loadAddr(16'h0010);
    runBlock("burst wr", 1'b0, 1'b0, 16'h0010, 4, 1'b0, 1'b0);
  endtask

  task automatic t_burst_from_mem_slow();
    loadAddr(16'h0040);
    runBlock("burst rd slow", 1'b0, 1'b1, 16'h0040, 5, 1'b1, 1'b0);
  endtask

  task automatic t_steal_to_mem();
    loadAddr(16'h0060);
    runBlock("steal wr", 1'b1, 1'b0, 16'h0060, 3, 1'b0, 1'b0);
  endtask

  task automatic t_steal_from_mem_slow();
    loadAddr(16'h00A0);
    runBlock("steal rd slow", 1'b1, 1'b1, 16'h00A0, 4, 1'b1, 1'b0);
  endtask

  task automatic t_continue_addr();
    // no address reload: continues at 0x00A4 (R3)
    runBlock("continue", 1'b0, 1'b0, 16'h00A4, 2, 1'b0, 1'b0);
  endtask

  task automatic t_zero_count();
    bit reqSeen = 0;
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b1; regWrData = 16'h0000;
    @(negedge clk);
    regWrEn = 1'b0;
    #2;
    chk(doneIrq && !busReq, "R7 zero count done next cycle", {doneIrq, busReq}, 2'b10);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #2;
      if (busReq) reqSeen = 1;
    end
    chk(!reqSeen, "R7 no request for zero count", reqSeen, 0);
  endtask

  task automatic t_busy_writes();
    bit reqSeen = 0;
    loadAddr(16'h00C0);
    runBlock("busy writes R8", 1'b0, 1'b0, 16'h00C0, 6, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #2;
      if (busReq) reqSeen = 1;
    end
    chk(!reqSeen, "R8 ignored control write started nothing", reqSeen, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    t_reset();
    t_burst_to_mem();
    t_burst_from_mem_slow();
    t_steal_to_mem();
    t_steal_from_mem_slow();
    t_continue_addr();
    t_zero_count();
    t_busy_writes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule